// File: doc/BRIEF.md
# Supervisor Protection-Key Rights and Enable Register Block

This block keeps the 32-bit rights word that governs protection keys on supervisor-mode pages. It also holds control register 4, from which it derives the two key-enable bits. Software reaches the rights word through a model-specific-register port. That port has an address, 64-bit write data, write and read strobes, and combinational read data. A write is accepted only when its upper 32 bits are zero. An accepted write produces a one-cycle translation-cache flush request. A rejected write produces a one-cycle general-protection fault request, whose error code is zero.

Control-register-4 writes come in on a separate path. Before a value is stored, the supervisor-key enable bit is cleared if the platform lacks the supervisor-key capability, and the user-key enable bit is cleared if it lacks the user-key capability. The supervisor capability input reflects bit 31 of ECX for feature leaf 7, subleaf 0. The page walker consumes the rights word and both enables.

Top module: `supkey_regs`

## Requirements
- R1: While reset is active and after it is released, the rights word, the stored CR4 value, both enables, the fault pulse and the flush pulse are all zero.
- R2: A write strobe at address 0x6E1 with data bits 63:32 all zero stores data bits 31:0 into the rights word, which appears on `skey_rights` one clock after the write.
- R3: Each accepted write raises `tlb_flush` for exactly the one cycle that follows it. `tlb_flush` then returns low unless another write is accepted.
- R4: A write strobe at address 0x6E1 with any of data bits 63:32 set leaves the rights word unchanged, raises `gp_fault` for the following cycle, and does not raise `tlb_flush`.
- R5: While `reg_rd` is high and the address is 0x6E1, `reg_rdata` equals the rights word zero-extended to 64 bits in the same cycle. Under any other combination of read strobe and address, `reg_rdata` is zero.
- R6: On a CR4 write, bit 24 (the supervisor-key enable) is stored only when `cap_skey` is 1 and is stored as 0 otherwise. `skey_en` follows the stored bit 24.
- R7: On a CR4 write, bit 22 (the user-key enable) is stored only when `cap_ukey` is 1 and is stored as 0 otherwise. `ukey_en` follows the stored bit 22.
- R8: On a CR4 write, every bit other than 22 and 24 is stored unchanged, and the stored value appears on `cr4_q` one clock later.
- R9: A write strobe at any address other than 0x6E1 changes neither the rights word nor CR4 and raises neither pulse.
- R10: `gp_fault` and `tlb_flush` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register port address |
| reg_wdata | input | 64 | Register port write data |
| reg_wr | input | 1 | Register port write strobe |
| reg_rd | input | 1 | Register port read strobe |
| reg_rdata | output | 64 | Register port read data (combinational) |
| cr4_wr | input | 1 | CR4 write strobe |
| cr4_wdata | input | 32 | CR4 write value |
| cap_skey | input | 1 | Supervisor-key capability present (leaf 7 ECX bit 31) |
| cap_ukey | input | 1 | User-key capability present |
| cr4_q | output | 32 | Stored CR4 value |
| skey_rights | output | 32 | Supervisor key rights word |
| skey_en | output | 1 | Effective supervisor-key enable |
| ukey_en | output | 1 | Effective user-key enable |
| gp_fault | output | 1 | One-cycle general-protection fault request (error code 0) |
| tlb_flush | output | 1 | One-cycle translation-cache flush request |

## Verification
A corrupted rights word shows up on `skey_rights` one clock after the write that caused it. It also shows up in `reg_rdata` in the same cycle as any read of 0x6E1. An address decode error or an error in the upper-half test shows up one cycle after the write, as a missing or extra fault or flush pulse. A masking error in CR4 shows up on `cr4_q` and on the enables one clock after the CR4 write. The bench covers all four capability combinations against every setting of the two enable bits.

// File: rtl/supkey_regs.sv
module supkey_regs #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RIGHTS_ADDR = 'h6E1,
  parameter int SKEY_BIT = 24,
  parameter int UKEY_BIT = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [63:0]       reg_rdata,
  input  logic              cr4_wr,
  input  logic [31:0]       cr4_wdata,
  input  logic              cap_skey,
  input  logic              cap_ukey,
  output logic [31:0]       cr4_q,
  output logic [31:0]       skey_rights,
  output logic              skey_en,
  output logic              ukey_en,
  output logic              gp_fault,
  output logic              tlb_flush
);

  logic        hit, wr_hit, upper_bad;
  logic [31:0] cr4_mask;

  assign hit       = (reg_addr == RIGHTS_ADDR);
  assign wr_hit    = reg_wr && hit;
  assign upper_bad = |reg_wdata[63:32];

  always_comb begin
    cr4_mask = '1;
    cr4_mask[SKEY_BIT] = cap_skey;
    cr4_mask[UKEY_BIT] = cap_ukey;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      skey_rights <= '0;
      cr4_q       <= '0;
      gp_fault    <= 1'b0;
      tlb_flush   <= 1'b0;
    end else begin
      gp_fault  <= wr_hit && upper_bad;
      tlb_flush <= wr_hit && !upper_bad;
      if (wr_hit && !upper_bad) skey_rights <= reg_wdata[31:0];
      if (cr4_wr) cr4_q <= cr4_wdata & cr4_mask;
    end
  end

  assign skey_en   = cr4_q[SKEY_BIT];
  assign ukey_en   = cr4_q[UKEY_BIT];
  assign reg_rdata = (reg_rd && hit) ? {32'd0, skey_rights} : 64'd0;

  a_r2_accept_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !upper_bad) |=> (skey_rights == $past(reg_wdata[31:0])) && tlb_flush);
  a_r4_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && upper_bad) |=> gp_fault && !tlb_flush && $stable(skey_rights));
  a_r9_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !hit) |=> !gp_fault && !tlb_flush && $stable(skey_rights));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gp_fault && tlb_flush));
  a_r6_skey_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cr4_wr && !cap_skey) |=> !skey_en);
  a_r7_ukey_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cr4_wr && !cap_ukey) |=> !ukey_en);
  a_r5_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[63:32] == 32'd0);

endmodule

// File: tb/supkey_regs_tb.sv
module supkey_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, cr4_wr = 1'b0;
  logic [31:0] cr4_wdata = '0;
  logic        cap_skey = 1'b0, cap_ukey = 1'b0;
  logic [63:0] reg_rdata;
  logic [31:0] cr4_q, skey_rights;
  logic        skey_en, ukey_en, gp_fault, tlb_flush;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_rights = '0;

  always #4 clk = ~clk;

  supkey_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cr4_wr(cr4_wr), .cr4_wdata(cr4_wdata), .cap_skey(cap_skey), .cap_ukey(cap_ukey),
    .cr4_q(cr4_q), .skey_rights(skey_rights), .skey_en(skey_en), .ukey_en(ukey_en),
    .gp_fault(gp_fault), .tlb_flush(tlb_flush));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_cr4(input logic [31:0] d);
    @(negedge clk);
    cr4_wdata = d; cr4_wr = 1'b1;
    @(negedge clk);
    cr4_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [31:0] a, input logic [63:0] exp, input string req);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 check(req, reg_rdata, exp);
    reg_rd = 1'b0;
    #1 check(req, reg_rdata, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rights in reset", {32'd0, skey_rights}, 64'd0);
    check("R1 pulses in reset", {62'd0, gp_fault, tlb_flush}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 cr4 after reset", {30'd0, skey_en, ukey_en}, 64'd0);
    check("R1 cr4_q after reset", {32'd0, cr4_q}, 64'd0);

    for (int k = 0; k < 32; k++) begin
      logic [31:0] v;
      v = (32'h1 << k) ^ (32'h5A3C_0000 + k);
      do_wr(32'h6E1, {32'd0, v});
      model_rights = v;
      check("R2 rights stored", {32'd0, skey_rights}, {32'd0, model_rights});
      check("R3 flush pulse", {63'd0, tlb_flush}, 64'd1);
      check("R10 no fault on accept", {63'd0, gp_fault}, 64'd0);
      @(negedge clk);
      check("R3 flush one cycle", {63'd0, tlb_flush}, 64'd0);
    end
    do_wr(32'h6E1, 64'hFFFF_FFFF);
    model_rights = 32'hFFFF_FFFF;
    check("R2 all ones", {32'd0, skey_rights}, 64'hFFFF_FFFF);

    for (int k = 32; k < 64; k++) begin
      do_wr(32'h6E1, (64'h1 << k) | 64'h1234_5678);
      check("R4 rights unchanged", {32'd0, skey_rights}, {32'd0, model_rights});
      check("R4 fault pulse", {63'd0, gp_fault}, 64'd1);
      check("R4 no flush", {63'd0, tlb_flush}, 64'd0);
      @(negedge clk);
      check("R4 fault one cycle", {63'd0, gp_fault}, 64'd0);
    end

    for (int k = 0; k < 14; k++) begin
      logic [31:0] a;
      a = (k < 12) ? (32'h6E1 ^ (32'h1 << k)) : (k == 12 ? 32'h0 : 32'h8000_06E1);
      do_wr(a, 64'h0000_0000_0BAD_F00D);
      check("R9 rights kept", {32'd0, skey_rights}, {32'd0, model_rights});
      check("R9 no pulses", {62'd0, gp_fault, tlb_flush}, 64'd0);
      do_wr(a, 64'hFFFF_0000_0000_0000);
      check("R9 no fault off-address", {62'd0, gp_fault, tlb_flush}, 64'd0);
      do_rd(a, 64'd0, "R5 off-address read zero");
    end

    do_rd(32'h6E1, {32'd0, model_rights}, "R5 read rights");
    do_wr(32'h6E1, 64'h0000_0000_8000_0001);
    model_rights = 32'h8000_0001;
    do_rd(32'h6E1, {32'd0, model_rights}, "R5 read after write");

    for (int c = 0; c < 4; c++) begin
      for (int e = 0; e < 4; e++) begin
        logic [31:0] d, x;
        @(negedge clk);
        cap_skey = c[1]; cap_ukey = c[0];
        d = 32'h0A0F_3C55 & ~32'h0140_0000;
        d[24] = e[1]; d[22] = e[0];
        x = d;
        if (!cap_skey) x[24] = 1'b0;
        if (!cap_ukey) x[22] = 1'b0;
        do_cr4(d);
        check("R6 skey_en", {63'd0, skey_en}, {63'd0, x[24]});
        check("R7 ukey_en", {63'd0, ukey_en}, {63'd0, x[22]});
        check("R8 cr4_q stored", {32'd0, cr4_q}, {32'd0, x});
      end
    end
    do_cr4(32'hFFFF_FFFF);
    check("R8 all ones full caps", {32'd0, cr4_q}, 64'hFFFF_FFFF);
    do_wr(32'h6E2, 64'd7);
    check("R9 cr4 unchanged by reg write", {32'd0, cr4_q}, 64'hFFFF_FFFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule